// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a clocked system read and write a 128K x 8 asynchronous static RAM. Its user side takes one request at a time on a valid/ready port: a read/write flag, a 17-bit address and, for writes, 8-bit data. Each finished access is marked by a single-cycle response strobe. For reads, the strobe carries the byte fetched. The memory side drives the address, an active-low and an active-high chip select, active-low output enable and write enable, and a data bus split into separate drive, sense and driver-enable signals. An external tri-state pad joins them into the bidirectional bus.

All minimum device timings are parameters in nanoseconds, next to the clock period. They are rounded up to whole clock counts at elaboration. A read holds the address with output enable low for the full access window and samples the bus on its last edge. It then releases the device and waits out the device's output turn-off time before it accepts anything else. A write drives the data one cycle before write enable falls, holds address and data through the whole pulse, and releases the drivers on the same edge where write enable rises. Output enable stays high for the entire write, so the device never drives back into the controller's drivers.

Back-pressure rules: a request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle. While `req_valid` is high, the request fields must be held steady until the request is taken. The response has no back-pressure. `rsp_valid` is high for exactly one cycle, and `rsp_rdata` must be taken in that cycle.

Top module: `sram_ctl`

## Requirements
- R1: While idle, mem_cs_n=1, mem_cs=0, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0, and these are also the values under reset. req_ready is high exactly when the controller is idle.
- R2: A request is taken only on a rising edge with req_valid and req_ready both high. A req_valid raised while req_ready is low, and withdrawn before req_ready returns, changes neither the memory pins nor the memory contents.
- R3: A read holds mem_cs_n=0, mem_cs=1, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for the read window, which is 7 cycles at default parameters. This starts in the cycle after acceptance, and mem_addr holds the accepted address unchanged throughout.
- R4: The value on mem_dq_in at the last rising edge of the read window appears on rsp_rdata with rsp_valid high for one cycle, in the cycle right after the window. Both selects and output enable are already released in that cycle.
- R5: After a read response the device stays deselected, mem_dq_oe stays 0 and req_ready stays low for the turnaround count, which is 3 cycles at default parameters. No write driver can therefore turn on within 25 ns of the device losing its output enable.
- R6: A write first spends one cycle with the selects active, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=1 driving the write data on mem_dq_out. mem_we_n is then low for the pulse count, which is 6 cycles at default parameters. Address, data and mem_dq_oe=1 stay unchanged while mem_we_n is low, and mem_oe_n is high for the whole write.
- R7: mem_dq_oe falls on the same edge where mem_we_n rises. A recovery stretch with the selects still active follows, 1 cycle at default parameters, and rsp_valid is high in its last cycle.
- R8: Each nanosecond minimum is converted to cycles by rounding up against CLK_PERIOD_NS, and any nonzero minimum gives at least one cycle. The read window is the largest of the cycle-time, address-access, select-access and OE-access counts. The turnaround is the output turn-off count less one. The write pulse covers the pulse width and data setup, and the setup cycle plus the pulse cover address and select to end of write. Recovery pads the write to the write cycle time. At 8 ns this gives 11 cycles per read after acceptance and 8 cycles per write.
- R9: mem_dq_oe is never high while mem_oe_n is low, nor within 25 ns after the device was last enabled to drive. mem_we_n is low only while both selects are active.
- R10: A read returns the byte most recently written to that address, for any address from 0 to 0x1FFFF, including reads that follow a write back-to-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Read data, valid with rsp_valid after a read |
| mem_addr | output | 17 | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data sensed from the memory bus |
| mem_dq_oe | output | 1 | Enable for the data-bus drivers |

## Verification
Two events share a cycle in this block. First, write enable rises on the same edge where the bus drivers let go. Second, the done strobe of one access coincides with the next request already waiting on the valid/ready port. The bench provokes both with requests held valid back-to-back, including a write directly after a read. A behavioural memory model times every pin change in nanoseconds. That model flags any driver overlap with the device's turn-off window, any short write pulse or address/select window, and returns inverted data whenever a read is sampled before its access times are met. A cycle-by-cycle reference model, separate from the design, compares every output on every clock and checks every returned byte against its own copy of the memory.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACCESS,
    ST_RD_DONE,
    ST_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER
  } ctl_state_e;

  // memory-side control intent for one state
  typedef struct packed {
    logic sel;   // both chip selects active
    logic rd;    // output enable asserted
    logic wr;    // write enable asserted
    logic drv;   // controller drives the data bus
  } pin_ctl_t;

  // nanoseconds to whole clocks, rounded up; zero stays zero
  function automatic int cyc_of(input int ns, input int period);
    if (ns <= 0) return 0;
    return (ns + period - 1) / period;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic pin_ctl_t pin_decode(input ctl_state_e st);
    pin_ctl_t p;
    p = '0;
    case (st)
      ST_RD_ACCESS:  begin p.sel = 1'b1; p.rd = 1'b1; end
      ST_WR_SETUP:   begin p.sel = 1'b1; p.drv = 1'b1; end
      ST_WR_PULSE:   begin p.sel = 1'b1; p.wr = 1'b1; p.drv = 1'b1; end
      ST_WR_RECOVER: begin p.sel = 1'b1; end
      default:       p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign last = (cnt_q == '0);

  // an expired window stays expired until reloaded (R8)
  assert_hold_expired_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !load) |=> last);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int RD_CYC   = 7,
  parameter int TA_CYC   = 3,
  parameter int WP_CYC   = 6,
  parameter int WREC_CYC = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic             tmr_last,
  output ctl_state_e       state_q,
  output ctl_state_e       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             req_ready,
  output logic             accept
);

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:       if (req_valid) state_d = req_we ? ST_WR_SETUP : ST_RD_ACCESS;
      ST_RD_ACCESS:  if (tmr_last) state_d = ST_RD_DONE;
      ST_RD_DONE:    state_d = ST_TURN;
      ST_TURN:       if (tmr_last) state_d = ST_IDLE;
      ST_WR_SETUP:   if (tmr_last) state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (tmr_last) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: if (tmr_last) state_d = ST_IDLE;
      default:       state_d = ST_IDLE;
    endcase
  end

  // every state entry reloads the window counter with its length minus one
  assign tmr_load = (state_d != state_q);

  always_comb begin
    case (state_d)
      ST_RD_ACCESS:  tmr_val = CNT_W'(RD_CYC - 1);
      ST_TURN:       tmr_val = CNT_W'(TA_CYC - 1);
      ST_WR_PULSE:   tmr_val = CNT_W'(WP_CYC - 1);
      ST_WR_RECOVER: tmr_val = CNT_W'(WREC_CYC - 1);
      default:       tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_taken_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_done_then_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_DONE) |=> (state_q == ST_TURN));

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_e        state_q,
  input  ctl_state_e        state_d,
  input  logic              accept,
  input  logic              tmr_last,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  pin_ctl_t nxt;
  assign nxt = pin_decode(state_d);

  // control pins come straight from flops so the strobes cannot glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_cs    <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
    end else begin
      mem_cs_n  <= !nxt.sel;
      mem_cs    <= nxt.sel;
      mem_oe_n  <= !nxt.rd;
      mem_we_n  <= !nxt.wr;
      mem_dq_oe <= nxt.drv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  // sample on the final edge of the read window, before the address moves
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (state_q == ST_RD_ACCESS && tmr_last) begin
      rsp_rdata <= mem_dq_in;
    end
  end

  assign rsp_valid = (state_q == ST_RD_DONE) ||
                     (state_q == ST_WR_RECOVER && tmr_last);

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_we_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs));

  assert_read_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

  assert_write_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out) && mem_dq_oe));

  assert_release_at_we_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_dq_oe);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 8,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_ACS_NS      = 55,
  parameter int T_AOE_NS      = 30,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 45,
  parameter int T_AW_NS       = 40,
  parameter int T_CW_NS       = 40,
  parameter int T_DW_NS       = 25,
  parameter int T_HZ_NS       = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int P = CLK_PERIOD_NS;
  localparam int RD_CYC = imax(1, imax(imax(cyc_of(T_RC_NS, P), cyc_of(T_AA_NS, P)),
                                       imax(cyc_of(T_ACS_NS, P), cyc_of(T_AOE_NS, P))));
  localparam int TA_CYC = imax(1, cyc_of(T_HZ_NS, P) - 1);
  localparam int WP_CYC = imax(1, imax(imax(cyc_of(T_WP_NS, P), cyc_of(T_DW_NS, P)),
                                       imax(cyc_of(T_AW_NS, P) - 1, cyc_of(T_CW_NS, P) - 1)));
  localparam int WREC_CYC = imax(1, cyc_of(T_WC_NS, P) - 1 - WP_CYC);
  localparam int MAX_CYC  = imax(imax(RD_CYC, TA_CYC), imax(WP_CYC, WREC_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  ctl_state_e       state_q, state_d;
  logic             tmr_load, tmr_last, accept;
  logic [CNT_W-1:0] tmr_val;

  sram_ctl_fsm #(
    .CNT_W(CNT_W), .RD_CYC(RD_CYC), .TA_CYC(TA_CYC),
    .WP_CYC(WP_CYC), .WREC_CYC(WREC_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we), .tmr_last(tmr_last),
    .state_q(state_q), .state_d(state_d),
    .tmr_load(tmr_load), .tmr_val(tmr_val),
    .req_ready(req_ready), .accept(accept)
  );

  sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  sram_ctl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n),
    .state_q(state_q), .state_d(state_d),
    .accept(accept), .tmr_last(tmr_last),
    .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assert_idle_parked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

  localparam int P = 8;

  function automatic int up(input int ns);
    return (ns + P - 1) / P;
  endfunction

  localparam int N_RD   = up(55);
  localparam int N_TA   = up(25) - 1;
  localparam int N_WP   = up(45);
  localparam int N_WREC = (up(55) - 1 - N_WP) > 1 ? (up(55) - 1 - N_WP) : 1;
  localparam int L_RD   = N_RD + 1 + N_TA;
  localparam int L_WR   = 1 + N_WP + N_WREC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  dq_in_b = '0;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  sram_ctl u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(dq_in_b), .mem_dq_oe(mem_dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // ---------------- behavioural memory device ----------------
  logic [7:0] dev_mem [int];
  logic [7:0] wr_latch = '0;
  wire dev_sel   = !mem_cs_n && mem_cs;
  wire dev_drive = dev_sel && !mem_oe_n && mem_we_n;
  longint t_addr = 0, t_sel = 0, t_oe = 0, t_wef = 0;
  longint t_off = -1000;

  function automatic logic [7:0] dev_rd(input logic [16:0] a);
    return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : 8'h00;
  endfunction

  always @(mem_addr)          t_addr = longint'($time);
  always @(posedge dev_sel)   t_sel  = longint'($time);
  always @(negedge mem_oe_n)  t_oe   = longint'($time);
  always @(negedge dev_drive) t_off  = longint'($time);
  always @(negedge mem_we_n)  t_wef  = longint'($time);

  always @(posedge mem_we_n) begin
    if (rst_n && dev_sel) begin
      longint now;
      now = longint'($time);
      chk(now - t_wef >= 45, "R6", "WE pulse ns", now - t_wef, 45);
      chk(now - t_addr >= 40, "R6", "address to end of write ns", now - t_addr, 40);
      chk(now - t_sel >= 40, "R6", "select to end of write ns", now - t_sel, 40);
      dev_mem[int'(mem_addr)] = wr_latch;
    end
  end

  // ticks at odd ns, never on a clock edge
  initial begin
    #1;
    forever begin
      longint now;
      now = longint'($time);
      if (dev_drive && (now - t_addr >= 55) && (now - t_sel >= 55) && (now - t_oe >= 30))
        dq_in_b = dev_rd(mem_addr);
      else
        dq_in_b = ~dev_rd(mem_addr);
      if (rst_n && mem_dq_oe && (dev_drive || (now - t_off < 25))) begin
        n_checks++; n_fail++;
        $display("FAIL R9 bus contention at %0t: actual=1 expected=0", $time);
      end
      if (rst_n && !mem_we_n) begin
        if (!mem_dq_oe) begin
          n_checks++; n_fail++;
          $display("FAIL R6 data undriven during WE low: actual=0 expected=1");
        end
        wr_latch = mem_dq_out;
      end
      #2;
    end
  end

  // ---------------- cycle reference model ----------------
  int          m_kind = 0;   // 0 idle, 1 read, 2 write
  int          m_k    = 0;
  logic [16:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  logic [7:0]  ref_mem [int];

  function automatic logic [7:0] ref_rd(input logic [16:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_kind = 0;
    end else if (m_kind != 0) begin
      if (m_k == ((m_kind == 1) ? L_RD : L_WR)) begin
        if (m_kind == 2) ref_mem[int'(m_addr)] = m_data;
        m_kind = 0;
      end else begin
        m_k++;
      end
    end else if (req_valid) begin
      m_kind = req_we ? 2 : 1;
      m_k    = 1;
      m_addr = req_addr;
      m_data = req_wdata;
    end
  end

  int oe_run = 0, we_run = 0, last_oe_run = 0, last_we_run = 0;
  int cycles = 0;

  always @(negedge clk) begin
    bit e_sel, e_oe, e_we, e_drv, e_rsp;
    string tag;
    cycles++;
    if (!mem_oe_n) oe_run++; else if (oe_run > 0) begin last_oe_run = oe_run; oe_run = 0; end
    if (!mem_we_n) we_run++; else if (we_run > 0) begin last_we_run = we_run; we_run = 0; end
    e_sel = 0; e_oe = 0; e_we = 0; e_drv = 0; e_rsp = 0; tag = "R1";
    if (m_kind == 1) begin
      if (m_k <= N_RD) begin e_sel = 1; e_oe = 1; tag = "R3"; end
      else if (m_k == N_RD + 1) begin e_rsp = 1; tag = "R4"; end
      else tag = "R5";
    end else if (m_kind == 2) begin
      e_sel = 1;
      if (m_k == 1) begin e_drv = 1; tag = "R6"; end
      else if (m_k <= 1 + N_WP) begin e_drv = 1; e_we = 1; tag = "R6"; end
      else begin tag = "R7"; e_rsp = (m_k == L_WR); end
    end
    if (rst_n) begin
      chk(req_ready == (m_kind == 0), tag, "req_ready", req_ready, m_kind == 0);
      chk(mem_cs_n == !e_sel && mem_cs == e_sel, tag, "selects", {mem_cs_n, mem_cs}, {!e_sel, e_sel});
      chk(mem_oe_n == !e_oe, tag, "mem_oe_n", mem_oe_n, !e_oe);
      chk(mem_we_n == !e_we, tag, "mem_we_n", mem_we_n, !e_we);
      chk(mem_dq_oe == e_drv, tag, "mem_dq_oe", mem_dq_oe, e_drv);
      chk(rsp_valid == e_rsp, tag, "rsp_valid", rsp_valid, e_rsp);
      if (e_sel) chk(mem_addr == m_addr, tag, "mem_addr", mem_addr, m_addr);
      if (e_drv) chk(mem_dq_out == m_data, tag, "mem_dq_out", mem_dq_out, m_data);
      if (e_rsp && m_kind == 1)
        chk(rsp_rdata == ref_rd(m_addr), "R4", "rsp_rdata", rsp_rdata, ref_rd(m_addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input bit we, input logic [16:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_check(input logic [16:0] a, input logic [7:0] exp, input string tag);
    do_req(1'b0, a, 8'h00);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == exp, tag, "read back", rsp_rdata, exp);
    @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [16:0] addrs [40];
    logic [7:0]  exp_mem [int];
    repeat (3) @(negedge clk);
    chk(mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe, "R1", "pins in reset",
        {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

    rd_check(17'h00005, 8'h00, "R4");
    do_req(1'b1, 17'h00000, 8'hA5);
    do_req(1'b1, 17'h1FFFF, 8'h3C);
    rd_check(17'h00000, 8'hA5, "R10");
    chk(last_oe_run == N_RD, "R8", "read window cycles", last_oe_run, N_RD);
    rd_check(17'h1FFFF, 8'h3C, "R10");
    chk(last_we_run == N_WP, "R8", "WE low cycles", last_we_run, N_WP);

    // read immediately followed by write: turnaround then drive
    do_req(1'b0, 17'h00000, 8'h00);
    do_req(1'b1, 17'h00000, 8'h5A);
    rd_check(17'h00000, 8'h5A, "R5");
    // write immediately followed by read of same byte
    do_req(1'b1, 17'h00123, 8'hC3);
    rd_check(17'h00123, 8'hC3, "R10");

    // a valid offered while busy and withdrawn is never taken
    do_req(1'b0, 17'h00007, 8'h00);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 17'h00007; req_wdata = 8'hFF;
    chk(req_ready == 1'b0, "R2", "busy while offered", req_ready, 0);
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (2) @(negedge clk);
    chk(mem_we_n && mem_cs_n && !mem_dq_oe, "R2", "no write after withdrawal",
        {mem_we_n, mem_cs_n, mem_dq_oe}, 3'b110);
    rd_check(17'h00007, 8'h00, "R2");

    for (int i = 0; i < 40; i++) begin
      logic [7:0] d;
      addrs[i] = 17'($urandom);
      d = 8'($urandom);
      exp_mem[int'(addrs[i])] = d;
      do_req(1'b1, addrs[i], d);
    end
    for (int i = 0; i < 40; i++)
      rd_check(addrs[i], exp_mem[int'(addrs[i])], "R10");

    wait_idle();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule